// File: doc/BRIEF.md
# System and CPU Clock Switch Controller

This block sequences the clocking of a small microcontroller that owns two oscillators: a fast main oscillator and a 32.768 kHz subsystem oscillator. Each oscillator is seen as a one-cycle tick on a common fast clock. The block produces the CPU clock as a one-cycle enable pulse, `cpu_en`, once per machine cycle. Downstream logic advances only when that pulse is high, so no clock multiplexer is needed.

After an external reset the block holds internal reset for a selectable oscillation-stabilization wait. It then runs the CPU at the slowest main-clock rate. Software has two registers. A 2-bit divider register picks the main-clock machine-cycle length. A 4-bit source register holds a source-select bit (bit 0) and a main-oscillator-stop bit (bit 3). A source change is deferred for a fixed count of machine cycles. The oscillator may only be stopped once the subsystem clock is in effect. A restart runs a new stabilization wait, and the way back to the main clock stays locked until that wait ends.

Top module: `cpuclk_sequencer`

## Requirements
- R1: After reset `sys_rst` and `stab_busy` stay high until 2^LONG_LOG (`long_wait`=1) or 2^SHORT_LOG (`long_wait`=0) main ticks have been counted. Both fall in the clock after the last such tick.
- R2: At release `pcc_q` is 0, and the first `cpu_en` comes with the 64th main tick after release.
- R3: Divider code `pcc_q` sets the machine cycle on the main clock: code 0 gives 64 main ticks, 1 gives 16, 2 gives 8 and 3 gives 4. Code 3 is the fastest.
- R4: `cpu_en` is high for single clocks only, only in a clock that carries a tick of the active source, and never while `sys_rst` is high.
- R5: When bit 0 of the source register (0 = main, 1 = subsystem) changes, `switch_busy` rises. `src_is_sub` takes the new value in the clock after the 46th `cpu_en` of the old source, and `switch_busy` then falls.
- R6: A write that sets bit 3 has no effect while the main clock is the active source or a switch is pending. `scc_q[3]` stays 0 and `main_osc_on` stays 1.
- R7: On the subsystem clock a machine cycle is 4 subsystem ticks, and main ticks have no effect on `cpu_en`.
- R8: An accepted set of bit 3 drops `main_osc_on`. Clearing bit 3 raises it and starts a stabilization count of the R1 length selected by `long_wait`, during which `stab_busy` is high.
- R9: A write that clears bit 0 has no effect while the main oscillator is stopped or its stabilization count is running.
- R10: Reset values are `pcc_q`=0 and `scc_q`=0. Bits 1 and 2 of `scc_q` always read 0, and register writes are ignored while `sys_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common fast clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| main_tick | input | 1 | One-clock pulse per main-oscillator period |
| sub_tick | input | 1 | One-clock pulse per subsystem-oscillator period |
| long_wait | input | 1 | Selects the long (1) or short (0) stabilization wait |
| pcc_we | input | 1 | Write strobe for the divider register |
| pcc_wdata | input | 2 | Divider code to write |
| scc_we | input | 1 | Write strobe for the source register |
| scc_wdata | input | 4 | Source register value to write |
| sys_rst | output | 1 | Internal reset, high during the power-up wait |
| cpu_en | output | 1 | One-clock CPU clock enable per machine cycle |
| pcc_q | output | 2 | Divider register |
| scc_q | output | 4 | Source register: bit 3 stop, bit 0 select |
| main_osc_on | output | 1 | Main oscillator enable |
| src_is_sub | output | 1 | Source currently in effect, 1 = subsystem |
| switch_busy | output | 1 | Source switch pending |
| stab_busy | output | 1 | Stabilization count running |

## Verification
The embedded assertions check these rules on every clock: no enable during internal reset, enables never on adjacent clocks, the main oscillator running whenever the main clock is in effect, a stop only while the subsystem clock is settled, a source change only on the closing enable of a pending switch, and a return to main only onto a running, stable oscillator. The bench scenarios show the exact counts: the two wait lengths, the 46-cycle delay in both directions, and the tick count per machine cycle for each divider code and for the subsystem. They also show the rejected writes, observed through `scc_q` and `main_osc_on`.

// File: rtl/cpuclk_sequencer.sv
`timescale 1ns/1ps
module cpuclk_sequencer #(
  parameter int LONG_LOG      = 17,
  parameter int SHORT_LOG     = 15,
  parameter int SWITCH_CYCLES = 46,
  parameter int SUB_DIV       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       long_wait,
  input  logic       pcc_we,
  input  logic [1:0] pcc_wdata,
  input  logic       scc_we,
  input  logic [3:0] scc_wdata,
  output logic       sys_rst,
  output logic       cpu_en,
  output logic [1:0] pcc_q,
  output logic [3:0] scc_q,
  output logic       main_osc_on,
  output logic       src_is_sub,
  output logic       switch_busy,
  output logic       stab_busy
);
  localparam int SW_W = $clog2(SWITCH_CYCLES + 1);

  logic [LONG_LOG-1:0] stab_cnt, stab_lim;
  logic [5:0]          mc_cnt, mc_lim, mc_last;
  logic [SW_W-1:0]     sw_cnt;
  logic                req_sub, stop_bit, src_sub, pending;
  logic                mc_tick, wr_ok, new_req, req_chg, sw_done, stop_ok, stab_end;

  assign stab_lim = long_wait ? {LONG_LOG{1'b1}} : ({LONG_LOG{1'b1}} >> (LONG_LOG - SHORT_LOG));

  always_comb begin
    case (pcc_q)
      2'd0:    mc_lim = 6'd63;
      2'd1:    mc_lim = 6'd15;
      2'd2:    mc_lim = 6'd7;
      default: mc_lim = 6'd3;
    endcase
  end

  assign mc_tick  = src_sub ? sub_tick : main_tick;
  assign mc_last  = src_sub ? 6'(SUB_DIV - 1) : mc_lim;
  assign cpu_en   = !sys_rst && mc_tick && (mc_cnt >= mc_last);

  assign wr_ok    = scc_we && !sys_rst;
  assign new_req  = scc_wdata[0] | (req_sub & ~(main_osc_on & ~stab_busy));
  assign req_chg  = wr_ok && (new_req != req_sub);
  assign sw_done  = pending && cpu_en && !req_chg && (sw_cnt == SW_W'(SWITCH_CYCLES - 1));
  assign stop_ok  = src_sub && !pending && scc_wdata[0];
  assign stab_end = stab_busy && main_tick && main_osc_on && (stab_cnt == stab_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst   <= 1'b1;
      stab_busy <= 1'b1;
      stab_cnt  <= '0;
      pcc_q     <= 2'd0;
      req_sub   <= 1'b0;
      stop_bit  <= 1'b0;
      src_sub   <= 1'b0;
      pending   <= 1'b0;
      sw_cnt    <= '0;
      mc_cnt    <= '0;
    end else begin
      if (stab_end) begin
        stab_busy <= 1'b0;
        sys_rst   <= 1'b0;
      end else if (stab_busy && main_tick && main_osc_on) begin
        stab_cnt <= stab_cnt + 1'b1;
      end

      if (pcc_we && !sys_rst) pcc_q <= pcc_wdata;

      if (wr_ok) begin
        if (!scc_wdata[3]) begin
          stop_bit <= 1'b0;
          if (stop_bit) begin
            stab_busy <= 1'b1;
            stab_cnt  <= '0;
          end
        end else if (stop_ok) begin
          stop_bit <= 1'b1;
        end
      end

      if (req_chg) begin
        req_sub <= new_req;
        pending <= (new_req != src_sub);
        sw_cnt  <= '0;
      end else if (sw_done) begin
        src_sub <= req_sub;
        pending <= 1'b0;
      end else if (pending && cpu_en) begin
        sw_cnt <= sw_cnt + 1'b1;
      end

      if (sys_rst || sw_done)  mc_cnt <= '0;
      else if (mc_tick)        mc_cnt <= cpu_en ? 6'd0 : mc_cnt + 1'b1;
    end
  end

  assign scc_q       = {stop_bit, 2'b00, req_sub};
  assign main_osc_on = !stop_bit;
  assign src_is_sub  = src_sub;
  assign switch_busy = pending;

  AST_NO_EN_IN_RST:   assert property (@(posedge clk) disable iff (!rst_n) sys_rst |-> !cpu_en);                // R4
  AST_EN_SINGLE:      assert property (@(posedge clk) disable iff (!rst_n) cpu_en |=> !cpu_en);                 // R4
  AST_SRC_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
                        (src_sub != $past(src_sub)) |-> ($past(pending) && $past(cpu_en)));                     // R5
  AST_OSC_ON_MAIN:    assert property (@(posedge clk) disable iff (!rst_n) !src_sub |-> main_osc_on);          // R6
  AST_STOP_SETTLED:   assert property (@(posedge clk) disable iff (!rst_n)
                        $fell(main_osc_on) |-> ($past(src_sub) && !$past(pending)));                            // R6
  AST_MAIN_STABLE:    assert property (@(posedge clk) disable iff (!rst_n)
                        $fell(src_sub) |-> (main_osc_on && !stab_busy));                                        // R9
endmodule

// File: tb/sim_cpuclk_sequencer.sv
`timescale 1ns/1ps
module sim_cpuclk_sequencer;
  logic clk = 0, rst_n = 0, main_tick = 0, sub_tick = 0, long_wait = 1;
  logic pcc_we = 0, scc_we = 0;
  logic [1:0] pcc_wdata = 0;
  logic [3:0] scc_wdata = 0;
  logic sys_rst, cpu_en, main_osc_on, src_is_sub, switch_busy, stab_busy;
  logic [1:0] pcc_q;
  logic [3:0] scc_q;
  int checks = 0, failures = 0, bad_en = 0;
  bit done = 0;

  cpuclk_sequencer #(.LONG_LOG(6), .SHORT_LOG(4), .SWITCH_CYCLES(46), .SUB_DIV(4)) u0 (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick), .long_wait(long_wait),
    .pcc_we(pcc_we), .pcc_wdata(pcc_wdata), .scc_we(scc_we), .scc_wdata(scc_wdata),
    .sys_rst(sys_rst), .cpu_en(cpu_en), .pcc_q(pcc_q), .scc_q(scc_q), .main_osc_on(main_osc_on),
    .src_is_sub(src_is_sub), .switch_busy(switch_busy), .stab_busy(stab_busy));

  always #4 clk = ~clk;

  function automatic int div_of(input logic [1:0] c);
    case (c) 2'd0: return 64; 2'd1: return 16; 2'd2: return 8; default: return 4; endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic step(input bit mt, input bit st, output bit en);
    @(negedge clk); main_tick = mt; sub_tick = st; #2; en = cpu_en;
    if (en && !(mt || st)) bad_en++;
    if (en && sys_rst) bad_en++;
    @(posedge clk); #1;
  endtask

  task automatic wr_scc(input logic [3:0] v);
    @(negedge clk); main_tick = 0; sub_tick = 0; scc_we = 1; scc_wdata = v;
    @(posedge clk); #1; scc_we = 0;
  endtask

  task automatic wr_pcc(input logic [1:0] v);
    @(negedge clk); main_tick = 0; sub_tick = 0; pcc_we = 1; pcc_wdata = v;
    @(posedge clk); #1; pcc_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; main_tick = 0; sub_tick = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
  endtask

  task automatic until_en(input int pm, input int ps, output int nm, output int ns);
    bit en = 0;
    nm = 0; ns = 0;
    for (int i = 0; i < 4000 && !en; i++) begin
      bit mt = ($urandom % 100) < pm;
      bit st = ($urandom % 100) < ps;
      step(mt, st, en);
      nm += mt; ns += st;
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int nm, ns, cnt, code;
    bit en, ok;
    void'($urandom(32'h5eed));
    // R10 / R1: reset state, long wait of 64 ticks, write during wait ignored
    long_wait = 1;
    do_reset();
    chk(sys_rst && stab_busy, "R1 reset holds sys_rst", sys_rst, 1);
    chk(pcc_q == 0 && scc_q == 0, "R10 reset values", {pcc_q, scc_q}, 0);
    for (int i = 0; i < 20; i++) step(1, 0, en);
    wr_pcc(2'd3);
    wr_scc(4'd1);
    chk(pcc_q == 0 && scc_q == 0, "R10 writes ignored in reset", {pcc_q, scc_q}, 0);
    for (int i = 0; i < 43; i++) step(1, 0, en);
    chk(sys_rst == 1, "R1 long wait before 64th tick", sys_rst, 1);
    step(1, 0, en);
    chk(sys_rst == 0 && stab_busy == 0, "R1 long wait release", sys_rst, 0);
    // R2: first machine cycle is 64 ticks
    until_en(60, 30, nm, ns);
    chk(nm == 64, "R2 first cycle main ticks", nm, 64);
    // R1: short wait
    long_wait = 0;
    do_reset();
    for (int i = 0; i < 15; i++) step(1, 0, en);
    chk(sys_rst == 1, "R1 short wait before 16th tick", sys_rst, 1);
    step(1, 0, en);
    chk(sys_rst == 0, "R1 short wait release", sys_rst, 0);
    long_wait = 1;
    // R3: random divider codes
    for (int k = 0; k < 8; k++) begin
      code = $urandom % 4;
      if (k == 0) code = 3;
      wr_pcc(2'(code));
      chk(pcc_q == 2'(code), "R3 divider register", pcc_q, code);
      until_en(50, 40, nm, ns);
      until_en(50, 40, nm, ns);
      chk(nm == div_of(2'(code)), "R3 main ticks per cycle", nm, div_of(2'(code)));
    end
    // R6: stop while main active is ignored
    wr_scc(4'd8);
    chk(scc_q == 0 && main_osc_on == 1, "R6 stop ignored on main", scc_q, 0);
    // R5: switch to subsystem after 46 main cycles
    wr_scc(4'd1);
    chk(switch_busy == 1 && src_is_sub == 0, "R5 switch pending", switch_busy, 1);
    ok = 1;
    for (int c = 1; c <= 45; c++) begin
      until_en(70, 50, nm, ns);
      if (src_is_sub) ok = 0;
      if (c == 10) begin
        wr_scc(4'd9);
        chk(scc_q == 4'd1 && main_osc_on, "R6 stop ignored while pending", scc_q, 1);
      end
    end
    chk(ok, "R5 source held for 45 cycles", src_is_sub, 0);
    until_en(70, 50, nm, ns);
    chk(src_is_sub == 1 && switch_busy == 0, "R5 source is sub after 46th", src_is_sub, 1);
    // R7: subsystem cycle of 4 sub ticks, main ticks ignored
    for (int k = 0; k < 4; k++) begin
      until_en(100, 50, nm, ns);
      if (k > 0) chk(ns == 4, "R7 sub ticks per cycle", ns, 4);
    end
    // R8: stop main oscillator
    wr_scc(4'd9);
    chk(scc_q == 4'd9 && main_osc_on == 0, "R8 oscillator stopped", scc_q, 9);
    // R9: return to main refused while stopped
    wr_scc(4'd8);
    chk(scc_q == 4'd9 && switch_busy == 0, "R9 clear bit0 ignored when stopped", scc_q, 9);
    // R8: restart and stabilization
    wr_scc(4'd1);
    chk(main_osc_on && stab_busy && scc_q == 4'd1, "R8 restart starts wait", stab_busy, 1);
    wr_scc(4'd0);
    chk(scc_q == 4'd1 && switch_busy == 0, "R9 clear bit0 ignored during wait", scc_q, 1);
    for (int i = 0; i < 63; i++) step(1, 0, en);
    chk(stab_busy == 1, "R8 wait before 64th tick", stab_busy, 1);
    step(1, 0, en);
    chk(stab_busy == 0, "R8 wait done after 64 ticks", stab_busy, 0);
    // R5: back to main after 46 sub cycles
    wr_scc(4'd0);
    chk(switch_busy == 1, "R5 return pending", switch_busy, 1);
    cnt = 0; ok = 1;
    for (int c = 1; c <= 45; c++) begin
      until_en(60, 60, nm, ns);
      if (!src_is_sub) ok = 0;
    end
    chk(ok, "R5 sub held for 45 cycles", src_is_sub, 1);
    until_en(60, 60, nm, ns);
    chk(src_is_sub == 0 && switch_busy == 0, "R5 main after 46th sub cycle", src_is_sub, 0);
    until_en(50, 50, nm, ns);
    until_en(50, 50, nm, ns);
    chk(nm == div_of(pcc_q), "R3 divider after return", nm, div_of(pcc_q));
    // R4: enable pulses only on tick clocks and never during reset
    chk(bad_en == 0, "R4 enable placement", bad_en, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule